// File: doc/BRIEF.md
# Row-Refreshed Nibble DRAM Array

This block models the data memory of a small 4-bit processor as a dynamic row array. Sixteen rows hold main data and four more rows hold status characters. Each row is sixteen bits wide and is split into four 4-bit registers. Every operation moves a whole row. A read, a write and a refresh each sense the row into a precharged sense latch, and a write or refresh restores the row from that latch. The wanted register is picked out of the latch by a multiplexer.

The surrounding sequencer drives one strobe per clock for each half of the memory and execute phases of the instruction cycle. During the memory phases the block refreshes the row chosen by an internal down-counter. During the execute phases it serves a read or a write on the row given by the latched source selection, or on a status row when a status access is flagged. The reset input does not clear anything by itself. It stops sensing and blocks the data bus, so the refresh path writes zeros. The whole array is clear once reset has been held for a full counter pass.

Top module: `nib_dram_array`

## Requirements
- R1: `ph_i` is one-hot or zero, one strobe per clock. Its bits are, from bit 0 to bit 7: M1 first half, M1 second half, M2 first half, M2 second half, X1 first half, X1 second half, X2 first half, X2 second half.
- R2: When the X2-first-half strobe fires with `rd_i` high and `rst_i` low, `oe_o` is 1. In the same cycle, `dout_o` shows the register selected by `reg_sel_i` from the row sensed at the X1-second-half strobe.
- R3: At every other time `oe_o` is 0 and `dout_o` is 0. This includes write cycles, cycles while reset is high and the idle state.
- R4: With `stat_i` high, the accessed row is status row `stat_idx_i`, and `src_row_i` is ignored. With `stat_i` low, it is main row `src_row_i`. Status rows and main rows are separate storage.
- R5: The M1-first-half and X1-first-half strobes set all 16 sense bits to one. A read with no sense strobe after the precharge returns 0xF.
- R6: At the M1-second-half strobe the refresh row is sensed, and at the M2-second-half strobe it is written back. A 5-bit counter then steps down by one and wraps from 0 to 31. A counter value below 16 selects main row `c`. A value of 16 or more selects status row `c mod 4`.
- R7: A sense strobe taken while `rst_i` is high loads zeros into the sense latch. Any later write-back of that latch stores zeros.
- R8: A write strobe taken while `rst_i` is high does not merge bus data. The row receives only the sensed latch contents.
- R9: A read never stores to the array. A row read after a reset-inhibited sense keeps its contents.
- R10: Holding `rst_i` high for 32 complete eight-strobe cycles leaves all 20 rows at zero.
- R11: Register `k` (selected by `reg_sel_i`) occupies row bits `[4k+3:4k]`. The X2-second-half strobe with `wr_i` high stores `din_i` there and stores the sensed values back into the other three registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| ph_i | input | 8 | One-hot half-phase strobes (encoding in R1) |
| rst_i | input | 1 | Inhibits row sensing and data-bus gating |
| src_row_i | input | 4 | Latched main-row selection |
| reg_sel_i | input | 2 | Register selection within the row |
| stat_i | input | 1 | Access targets a status row |
| stat_idx_i | input | 2 | Status row index |
| rd_i | input | 1 | Current execute cycle is a read |
| wr_i | input | 1 | Current execute cycle is a write |
| din_i | input | 4 | Data bus into the array |
| dout_o | output | 4 | Data bus out of the array |
| oe_o | output | 1 | Data bus drive enable |

## Verification
The bench first fills every row with nonzero nibbles and reads all 80 registers back through both main and status addressing. A design that merged the wrong register, or let `src_row_i` leak into a status access, would show a mismatch in some other row. Over 32 rounds it then applies reset to one refresh sense at a time and finds which row became zero. A counter that ran upward, failed to wrap, or mapped status values on the wrong bits would clear rows out of the predicted order. Single-strobe reset pulses on the sense and write halves catch a design that writes back after a read, lets bus data in during reset, or keeps stale latch data when sensing is inhibited. A skipped sense strobe exposes a missing precharge.

// File: rtl/nda_pkg.sv
package nda_pkg;
   // Half-phase strobe positions in ph_i; the order is the sequence of a cycle.
   localparam int PH_N   = 8;
   localparam int PH_M1A = 0;
   localparam int PH_M1B = 1;
   localparam int PH_M2A = 2;
   localparam int PH_M2B = 3;
   localparam int PH_X1A = 4;
   localparam int PH_X1B = 5;
   localparam int PH_X2A = 6;
   localparam int PH_X2B = 7;
endpackage

// File: rtl/nda_refresh_ctr.sv
module nda_refresh_ctr #(
   parameter int MAIN_ROWS = 16,
   parameter int STAT_ROWS = 4,
   parameter int CNT_W     = 5,
   parameter int ROW_AW    = 5
) (
   input  logic              clk,
   input  logic              step_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [ROW_AW-1:0] row_o
);
   localparam int MAIN_AW = $clog2(MAIN_ROWS);
   localparam int STAT_AW = $clog2(STAT_ROWS);

   logic [CNT_W-1:0] cnt_q;

   // Free-running down-counter; wraps naturally from zero to all ones (R6).
   always_ff @(posedge clk) begin
      if (step_i) cnt_q <= cnt_q - 1'b1;
   end

   assign cnt_o = cnt_q;

   // Top bit picks the status bank; status rows repeat across that half.
   always_comb begin
      if (cnt_q[CNT_W-1])
         row_o = ROW_AW'(MAIN_ROWS) + ROW_AW'(cnt_q[STAT_AW-1:0]);
      else
         row_o = ROW_AW'(cnt_q[MAIN_AW-1:0]);
   end
endmodule

// File: rtl/nda_sense_latch.sv
module nda_sense_latch #(
   parameter int ROW_W = 16
) (
   input  logic             clk,
   input  logic             pre_i,
   input  logic             load_i,
   input  logic             inhibit_i,
   input  logic [ROW_W-1:0] row_i,
   output logic [ROW_W-1:0] q_o
);
   logic [ROW_W-1:0] q;

   always_ff @(posedge clk) begin
      if (pre_i)       q <= '1;
      else if (load_i) q <= inhibit_i ? '0 : row_i;
   end

   assign q_o = q;
endmodule

// File: rtl/nda_row_store.sv
module nda_row_store #(
   parameter int ROW_W  = 16,
   parameter int ROWS   = 20,
   parameter int ROW_AW = 5
) (
   input  logic              clk,
   input  logic [ROW_AW-1:0] rd_row_i,
   output logic [ROW_W-1:0]  rd_data_o,
   input  logic              we_i,
   input  logic [ROW_AW-1:0] wr_row_i,
   input  logic [ROW_W-1:0]  wr_data_i
);
   logic [ROW_W-1:0] mem [ROWS];

   always_ff @(posedge clk) begin
      if (we_i) mem[wr_row_i] <= wr_data_i;
   end

   assign rd_data_o = mem[rd_row_i];
endmodule

// File: rtl/nib_dram_array.sv
module nib_dram_array
   import nda_pkg::*;
#(
   parameter int RW        = 4,
   parameter int NREG      = 4,
   parameter int MAIN_ROWS = 16,
   parameter int STAT_ROWS = 4,
   localparam int ROW_W    = RW * NREG,
   localparam int ROWS     = MAIN_ROWS + STAT_ROWS,
   localparam int ROW_AW   = $clog2(ROWS),
   localparam int MAIN_AW  = $clog2(MAIN_ROWS),
   localparam int STAT_AW  = $clog2(STAT_ROWS),
   localparam int REG_AW   = $clog2(NREG),
   localparam int CNT_W    = MAIN_AW + 1
) (
   input  logic               clk,
   input  logic [PH_N-1:0]    ph_i,
   input  logic               rst_i,
   input  logic [MAIN_AW-1:0] src_row_i,
   input  logic [REG_AW-1:0]  reg_sel_i,
   input  logic               stat_i,
   input  logic [STAT_AW-1:0] stat_idx_i,
   input  logic               rd_i,
   input  logic               wr_i,
   input  logic [RW-1:0]      din_i,
   output logic [RW-1:0]      dout_o,
   output logic               oe_o
);
   // Elaboration-time parameter checks
   if (MAIN_ROWS < 2 || MAIN_ROWS != (1 << MAIN_AW)) begin : g_bad_main
      $error("MAIN_ROWS must be a power of two of at least 2");
   end
   if (STAT_ROWS < 2 || STAT_ROWS != (1 << STAT_AW) || STAT_ROWS > MAIN_ROWS) begin : g_bad_stat
      $error("STAT_ROWS must be a power of two between 2 and MAIN_ROWS");
   end
   if (NREG < 2 || NREG != (1 << REG_AW)) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 2");
   end
   if (RW < 1) begin : g_bad_rw
      $error("RW must be positive");
   end

   logic [CNT_W-1:0]  ref_cnt;
   logic [ROW_AW-1:0] ref_row;
   logic [ROW_AW-1:0] acc_sel;
   logic [ROW_AW-1:0] acc_row_q;
   logic [ROW_AW-1:0] sense_row;
   logic [ROW_W-1:0]  row_data;
   logic [ROW_W-1:0]  sense_q;
   logic [ROW_W-1:0]  merged;
   logic [ROW_W-1:0]  store_data;
   logic [ROW_AW-1:0] store_row;
   logic              store_en;
   logic              gate_bus;
   logic              refresh_wb;

   // Refresh row source; steps after its write-back (R6)
   nda_refresh_ctr #(
      .MAIN_ROWS(MAIN_ROWS), .STAT_ROWS(STAT_ROWS), .CNT_W(CNT_W), .ROW_AW(ROW_AW)
   ) u_ref (
      .clk(clk), .step_i(ph_i[PH_M2B]), .cnt_o(ref_cnt), .row_o(ref_row)
   );

   // Access row: status bank or main bank (R4)
   assign acc_sel = stat_i ? ROW_AW'(MAIN_ROWS) + ROW_AW'(stat_idx_i)
                           : ROW_AW'(src_row_i);

   always_ff @(posedge clk) begin
      if (ph_i[PH_X1B]) acc_row_q <= acc_sel;
   end

   assign sense_row = ph_i[PH_M1B] ? ref_row : acc_sel;

   nda_row_store #(.ROW_W(ROW_W), .ROWS(ROWS), .ROW_AW(ROW_AW)) u_store (
      .clk(clk), .rd_row_i(sense_row), .rd_data_o(row_data),
      .we_i(store_en), .wr_row_i(store_row), .wr_data_i(store_data)
   );

   // Precharge on first halves, sense on second halves, zeros under reset (R5, R7)
   nda_sense_latch #(.ROW_W(ROW_W)) u_sense (
      .clk(clk),
      .pre_i(ph_i[PH_M1A] | ph_i[PH_X1A]),
      .load_i(ph_i[PH_M1B] | ph_i[PH_X1B]),
      .inhibit_i(rst_i),
      .row_i(row_data),
      .q_o(sense_q)
   );

   // Bus gating is blocked by reset (R8)
   assign gate_bus = ph_i[PH_X2B] & wr_i & ~rst_i;

   for (genvar g = 0; g < NREG; g++) begin : g_merge
      assign merged[g*RW +: RW] = (gate_bus && reg_sel_i == REG_AW'(g))
                                  ? din_i : sense_q[g*RW +: RW];
   end

   // Refresh and write are the only stores; a read never writes back (R9, R11)
   assign refresh_wb = ph_i[PH_M2B];
   assign store_en   = refresh_wb | (ph_i[PH_X2B] & wr_i);
   assign store_row  = refresh_wb ? ref_row : acc_row_q;
   assign store_data = refresh_wb ? sense_q : merged;

   // Output bus (R2, R3)
   assign oe_o   = ph_i[PH_X2A] & rd_i & ~rst_i;
   assign dout_o = oe_o ? sense_q[RW*int'(reg_sel_i) +: RW] : '0;
endmodule

// File: rtl/nda_checker.sv
module nda_checker
   import nda_pkg::*;
#(
   parameter int ROW_W  = 16,
   parameter int CNT_W  = 5,
   parameter int ROW_AW = 5,
   parameter int ROWS   = 20
) (
   input logic              clk,
   input logic              rst,
   input logic [PH_N-1:0]   ph,
   input logic [ROW_W-1:0]  sense,
   input logic [CNT_W-1:0]  cnt,
   input logic [ROW_AW-1:0] ref_row
);
   // R1: at most one strobe per clock
   p_strobe_onehot_r1: assert property (@(posedge clk) disable iff (rst)
      $onehot0(ph));

   // R5: a precharge leaves every sense bit high
   p_precharge_ones_r5: assert property (@(posedge clk) disable iff (rst)
      (ph[PH_M1A] || ph[PH_X1A]) |=> (sense == {ROW_W{1'b1}}));

   // R7: reset is the condition under test here, so it cannot disable the check
   p_sense_inhibit_r7: assert property (@(posedge clk)
      ((ph[PH_M1B] || ph[PH_X1B]) && rst) |=> (sense == '0));

   // R6: one step down per refresh write-back, with wrap
   p_cnt_step_r6: assert property (@(posedge clk) disable iff (rst)
      ph[PH_M2B] |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

   // R6: the counter holds between write-backs
   p_cnt_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !ph[PH_M2B] |=> $stable(cnt));

   // R6: the refresh row always lands inside the array
   p_ref_row_range_r6: assert property (@(posedge clk) disable iff (rst)
      ph[PH_M1B] |-> (int'(ref_row) < ROWS));
endmodule

bind nib_dram_array nda_checker #(
   .ROW_W(ROW_W), .CNT_W(CNT_W), .ROW_AW(ROW_AW), .ROWS(ROWS)
) u_chk (
   .clk(clk), .rst(rst_i), .ph(ph_i), .sense(sense_q), .cnt(ref_cnt), .ref_row(ref_row)
);

// File: tb/nib_dram_array_test.sv
module nib_dram_array_test;
   logic       clk = 1'b0;
   logic [7:0] ph_i = 8'h0;
   logic       rst_i = 1'b0;
   logic [3:0] src_row_i = 4'h0;
   logic [1:0] reg_sel_i = 2'h0;
   logic       stat_i = 1'b0;
   logic [1:0] stat_idx_i = 2'h0;
   logic       rd_i = 1'b0;
   logic       wr_i = 1'b0;
   logic [3:0] din_i = 4'h0;
   logic [3:0] dout_o;
   logic       oe_o;

   int checks = 0;
   int errors = 0;
   int ncyc   = 0;
   logic [15:0] model [20];
   int cleared_row [32];
   int round_cyc   [32];

   always #2 clk = ~clk;

   nib_dram_array uut (
      .clk(clk), .ph_i(ph_i), .rst_i(rst_i), .src_row_i(src_row_i),
      .reg_sel_i(reg_sel_i), .stat_i(stat_i), .stat_idx_i(stat_idx_i),
      .rd_i(rd_i), .wr_i(wr_i), .din_i(din_i), .dout_o(dout_o), .oe_o(oe_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] pat(input int row, input int rg, input int salt);
      return 4'(((row * 3 + rg * 7 + salt) % 15) + 1);
   endfunction

   // Counter value to row number, per R6
   function automatic int map_row(input int c);
      return (c >= 16) ? 16 + (c % 4) : c;
   endfunction

   // One instruction cycle; fire selects strobes, rmask gives rst per strobe
   task automatic run_cycle(input logic [7:0] fire, input logic [7:0] rmask,
                            output logic [3:0] rv, output logic ro);
      rv = 4'h0;
      ro = 1'b0;
      for (int p = 0; p < 8; p++) begin
         @(negedge clk);
         ph_i  = fire[p] ? 8'(1 << p) : 8'h0;
         rst_i = rmask[p];
         if (p == 6) begin
            #1;
            rv = dout_o;
            ro = oe_o;
         end
      end
      @(negedge clk);
      ph_i  = 8'h0;
      rst_i = 1'b0;
      if (fire[3]) ncyc++;
   endtask

   task automatic set_addr(input int row, input int rg);
      if (row >= 16) begin
         stat_i     = 1'b1;
         stat_idx_i = 2'(row - 16);
         src_row_i  = 4'(row ^ 5);    // must be ignored (R4)
      end else begin
         stat_i     = 1'b0;
         src_row_i  = 4'(row);
         stat_idx_i = 2'(row + 1);    // must be ignored (R4)
      end
      reg_sel_i = 2'(rg);
   endtask

   task automatic write_nib(input int row, input int rg, input logic [3:0] v,
                            input logic [7:0] rmask);
      logic [3:0] rv;
      logic       ro;
      set_addr(row, rg);
      wr_i = 1'b1; rd_i = 1'b0; din_i = v;
      run_cycle(8'hFF, rmask, rv, ro);
      wr_i = 1'b0;
      check("R3 oe low on write", int'(ro), 0);
   endtask

   task automatic read_nib(input int row, input int rg, input logic [7:0] fire,
                           input logic [7:0] rmask, output logic [3:0] v, output logic o);
      set_addr(row, rg);
      rd_i = 1'b1; wr_i = 1'b0;
      run_cycle(fire, rmask, v, o);
      rd_i = 1'b0;
   endtask

   task automatic verify_row(input int row, input string req);
      logic [3:0] v;
      logic       o;
      for (int rg = 0; rg < 4; rg++) begin
         read_nib(row, rg, 8'hFF, 8'h00, v, o);
         check({req, " read enable"}, int'(o), 1);
         check(req, int'(v), int'(model[row][rg*4 +: 4]));
      end
   endtask

   task automatic fill_all(input int salt);
      for (int r = 0; r < 20; r++)
         for (int rg = 0; rg < 4; rg++) begin
            write_nib(r, rg, pat(r, rg, salt), 8'h00);
            model[r][rg*4 +: 4] = pat(r, rg, salt);
         end
   endtask

   initial begin : watchdog
      #(4 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [3:0] v;
      logic       o;
      int         c0;
      bit         have_c0;

      #1;
      check("R3 idle oe", int'(oe_o), 0);
      check("R3 idle dout", int'(dout_o), 0);

      // R1/R2/R4/R11: fill every register, then read all back
      fill_all(0);
      for (int r = 0; r < 20; r++) verify_row(r, "R2 R4 R11 sweep");

      // R11: single-register overwrite keeps the other three
      write_nib(3, 2, 4'hA, 8'h00);
      model[3][11:8] = 4'hA;
      verify_row(3, "R11 merge");

      // R3: a cycle with neither read nor write
      set_addr(7, 1);
      run_cycle(8'hFF, 8'h00, v, o);
      check("R3 no-read oe", int'(o), 0);
      check("R3 no-read dout", int'(v), 0);

      // R5: skip the X1 sense strobe, precharge alone shows through
      read_nib(6, 1, 8'hDF, 8'h00, v, o);
      check("R5 precharge value", int'(v), 15);
      verify_row(6, "R5 row intact");

      // R7/R9: reset at X1 sense only; read returns zero, row not written back
      read_nib(5, 0, 8'hFF, 8'h20, v, o);
      check("R7 inhibited read enable", int'(o), 1);
      check("R7 inhibited read value", int'(v), 0);
      verify_row(5, "R9 no write-back on read");

      // R7: reset at X1 sense during a write; other registers become zero
      write_nib(9, 2, 4'h6, 8'h20);
      model[9] = 16'h0600;
      verify_row(9, "R7 write after inhibited sense");

      // R8: reset at X2 store; bus data blocked, row keeps sensed contents
      write_nib(10, 1, ~model[10][7:4], 8'h80);
      verify_row(10, "R8 bus blocked");

      // R3: read while reset is high during X2 first half
      read_nib(4, 1, 8'hFF, 8'h40, v, o);
      check("R3 oe low in reset", int'(o), 0);
      check("R3 dout zero in reset", int'(v), 0);

      // R6: 32 rounds, each clears the current refresh row via reset at M1 sense
      fill_all(4);
      for (int k = 0; k < 32; k++) begin
         round_cyc[k] = ncyc;
         set_addr(0, 0);
         run_cycle(8'hFF, 8'h02, v, o);
         cleared_row[k] = -1;
         for (int r = 0; r < 20; r++) begin
            logic [15:0] rowv;
            for (int rg = 0; rg < 4; rg++) begin
               read_nib(r, rg, 8'hFF, 8'h00, v, o);
               rowv[rg*4 +: 4] = v;
            end
            if (rowv == 16'h0 && cleared_row[k] < 0) cleared_row[k] = r;
         end
         if (cleared_row[k] >= 0)
            for (int rg = 0; rg < 4; rg++)
               write_nib(cleared_row[k], rg, model[cleared_row[k]][rg*4 +: 4], 8'h00);
         for (int p = 0; p < 11 + k % 3; p++) run_cycle(8'hFF, 8'h00, v, o);
      end
      have_c0 = 1'b0;
      c0 = 0;
      for (int k = 0; k < 32; k++)
         if (!have_c0 && cleared_row[k] >= 0 && cleared_row[k] < 16) begin
            c0 = (cleared_row[k] + round_cyc[k]) % 32;
            have_c0 = 1'b1;
         end
      check("R6 main row found", int'(have_c0), 1);
      for (int k = 0; k < 32; k++)
         check("R6 refresh order", cleared_row[k],
               map_row(((c0 - round_cyc[k]) % 32 + 32) % 32));

      // R10: 32 full cycles in reset with a write pending; everything zero
      fill_all(9);
      set_addr(2, 3);
      wr_i = 1'b1; din_i = 4'hF;
      for (int n = 0; n < 32; n++) begin
         run_cycle(8'hFF, 8'hFF, v, o);
         check("R3 oe low during clear", int'(o), 0);
      end
      wr_i = 1'b0;
      for (int r = 0; r < 20; r++) model[r] = 16'h0;
      for (int r = 0; r < 20; r++) verify_row(r, "R10 full clear");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule